// File: doc/BRIEF.md
# Fractional/Integer Multiply-Accumulate Unit

This block multiplies two 16-bit operands and folds the product into a 40-bit accumulator. The product can replace the accumulator, be added to it, or be subtracted from it. The operands can be signed, unsigned, or mixed (signed first operand, unsigned second). They can be read as fractions or as integers.

When both operands are signed fractions, the product is doubled so that it stays aligned to the binary point. The single case that cannot be represented, -1.0 times -1.0, is clamped.

Each operation also produces an extracted result taken from the new accumulator value:

- a 16-bit half-word, which is rounded, truncated or integer-saturated, or
- a 32-bit word, which is always saturated.

An overflow flag reports any clamp or wrap that happened during the operation. All results are registered and appear one cycle after an enabled operation.

Top module: `mac_unit`

## Requirements
- R1: While `rst_n` is low, and until the first enabled operation after it, `acc_o`, `res_o` and `ovf_o` are all zero.
- R2: With `en` high at a rising edge, the accumulator, result and flag take their new values at that edge. With `en` low they hold.
- R3: Operand format: `ops_mixed`=1 reads `op_a` as signed and `op_b` as unsigned. Otherwise `ops_unsigned`=1 reads both as unsigned and `ops_unsigned`=0 reads both as signed. The product is doubled only when `frac_mode`=1 and both operands are signed. Accumulator and extraction are unsigned exactly when both operands are unsigned.
- R4: A signed fractional product of 0x8000 by 0x8000 yields 0x7FFFFFFF and sets `ovf_o`.
- R5: `acc_op` selects the accumulator update: 2'b01 adds the product, 2'b10 subtracts it, and 2'b00 or 2'b11 loads it. A result outside the 40-bit range of the current signedness keeps its low 40 bits and sets `ovf_o`.
- R6: With `acc_clamp32`=1 the new accumulator is clamped to the 32-bit range of the current signedness, and a clamp sets `ovf_o`.
- R7: Half-word output in fractional mode with `trunc_half`=0 adds 0x8000 to the accumulator, shifts right by 16 (arithmetic shift), then saturates to 16 bits. The value sits in `res_o[15:0]`. `res_o[31:16]` holds its sign extension when signed and zero when unsigned.
- R8: With `trunc_half`=1 in fractional half-word mode, the accumulator is shifted right by 16 with no rounding, then saturated to 16 bits.
- R9: Half-word output in integer mode (`frac_mode`=0) is the accumulator saturated to 16 bits.
- R10: With `word_sel`=1 the result is the accumulator saturated to 32 bits, in any operand format.
- R11: `ovf_o` is the OR of product saturation, accumulator wrap or clamp, and output saturation for that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operation enable |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| ops_unsigned | input | 1 | Both operands unsigned |
| ops_mixed | input | 1 | op_a signed, op_b unsigned |
| frac_mode | input | 1 | Fractional (1) or integer (0) |
| trunc_half | input | 1 | Truncate instead of round for the half-word |
| acc_clamp32 | input | 1 | Clamp the accumulator to 32 bits |
| word_sel | input | 1 | 32-bit word output (1) or half-word (0) |
| acc_op | input | 2 | Accumulator update selector |
| acc_o | output | 40 | Accumulator |
| res_o | output | 32 | Extracted result |
| ovf_o | output | 1 | Overflow flag of the last operation |

## Verification
Every result (accumulator, extracted value and flag) is due at the rising edge that samples `en` high, so it is visible one cycle after the inputs were applied. The bench drives a full operation on a falling edge and compares all three outputs on the next falling edge, half a cycle clear of the update. Idle cycles with `en` low are compared against the previously expected values to confirm the hold.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD     = 2'b00,
    ACC_ADD      = 2'b01,
    ACC_SUB      = 2'b10,
    ACC_LOAD_ALT = 2'b11
  } acc_op_e;

  // True when v lies outside the w-bit range of the given signedness
  function automatic logic out_of_range(input logic signed [63:0] v,
                                        input int unsigned w,
                                        input logic sgn);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = sgn ? (64'sd1 <<< (w - 1)) - 64'sd1 : (64'sd1 <<< w) - 64'sd1;
    lo = sgn ? -(64'sd1 <<< (w - 1)) : 64'sd0;
    return (v > hi) || (v < lo);
  endfunction

  // Clamp v into the w-bit range of the given signedness
  function automatic logic signed [63:0] clamp_val(input logic signed [63:0] v,
                                                   input int unsigned w,
                                                   input logic sgn);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = sgn ? (64'sd1 <<< (w - 1)) - 64'sd1 : (64'sd1 <<< w) - 64'sd1;
    lo = sgn ? -(64'sd1 <<< (w - 1)) : 64'sd0;
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W = 16
) (
  input  logic [OP_W-1:0]            a,
  input  logic [OP_W-1:0]            b,
  input  logic                       a_sgn,
  input  logic                       b_sgn,
  input  logic                       dbl,
  output logic signed [2*OP_W+1:0]   prod,
  output logic                       sat
);
  localparam int PW = 2*OP_W + 2;

  logic signed [OP_W:0] ax;
  logic signed [OP_W:0] bx;
  logic signed [PW-1:0] raw;

  always_comb begin
    ax  = $signed({a_sgn & a[OP_W-1], a});
    bx  = $signed({b_sgn & b[OP_W-1], b});
    raw = PW'(ax) * PW'(bx);
    sat = 1'b0;
    if (dbl) begin
      // only (-1.0)*(-1.0) reaches 2^(2*OP_W-2); doubled it exceeds the word
      if (raw == (PW'(1) <<< (2*OP_W - 2))) begin
        prod = (PW'(1) <<< (2*OP_W - 1)) - PW'(1);
        sat  = 1'b1;
      end else begin
        prod = raw <<< 1;
      end
    end else begin
      prod = raw;
    end
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0]          acc_q,
  input  logic signed [2*OP_W+1:0]  prod,
  input  logic [1:0]                op,
  input  logic                      sgn,
  input  logic                      clamp_rw,
  output logic [ACC_W-1:0]          acc_d,
  output logic                      ovf
);
  localparam int RW = 2*OP_W;

  logic signed [63:0] acc_x;
  logic signed [63:0] prod_x;
  logic signed [63:0] sum;
  logic signed [63:0] clamped;

  always_comb begin
    acc_x  = sgn ? 64'($signed(acc_q)) : $signed(64'(acc_q));
    prod_x = 64'(prod);
    unique case (acc_op_e'(op))
      ACC_ADD: sum = acc_x + prod_x;
      ACC_SUB: sum = acc_x - prod_x;
      default: sum = prod_x;
    endcase
    if (clamp_rw) begin
      clamped = clamp_val(sum, RW, sgn);
      acc_d   = clamped[ACC_W-1:0];
      ovf     = out_of_range(sum, RW, sgn);
    end else begin
      clamped = sum;
      acc_d   = sum[ACC_W-1:0];
      ovf     = out_of_range(sum, ACC_W, sgn);
    end
  end
endmodule

// File: rtl/mac_extract.sv
module mac_extract
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0]   acc,
  input  logic               sgn,
  input  logic               frac,
  input  logic               trunc,
  input  logic               word,
  output logic [2*OP_W-1:0]  res,
  output logic               sat
);
  localparam int RW = 2*OP_W;

  logic signed [63:0] v;
  logic signed [63:0] t;
  logic signed [63:0] q;
  logic signed [63:0] c;

  always_comb begin
    v = sgn ? 64'($signed(acc)) : $signed(64'(acc));
    t = (frac && !trunc) ? v + (64'sd1 <<< (OP_W - 1)) : v;
    q = frac ? (t >>> OP_W) : t;
    if (word) begin
      c   = clamp_val(v, RW, sgn);
      sat = out_of_range(v, RW, sgn);
      res = c[RW-1:0];
    end else begin
      c   = clamp_val(q, OP_W, sgn);
      sat = out_of_range(q, OP_W, sgn);
      res = sgn ? RW'($signed(c[OP_W-1:0])) : RW'(c[OP_W-1:0]);
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  input  logic                ops_unsigned,
  input  logic                ops_mixed,
  input  logic                frac_mode,
  input  logic                trunc_half,
  input  logic                acc_clamp32,
  input  logic                word_sel,
  input  logic [1:0]          acc_op,
  output logic [ACC_W-1:0]    acc_o,
  output logic [2*OP_W-1:0]   res_o,
  output logic                ovf_o
);
  localparam int RW = 2*OP_W;

  logic                      both_sgn;
  logic                      any_sgn;
  logic signed [RW+1:0]      prod;
  logic                      prod_sat;
  logic [ACC_W-1:0]          acc_d;
  logic                      acc_ovf;
  logic [RW-1:0]             res_d;
  logic                      res_sat;
  logic                      ovf_d;

  logic [ACC_W-1:0]          acc_q;
  logic [RW-1:0]             res_q;
  logic                      ovf_q;

  assign both_sgn = !ops_unsigned && !ops_mixed;
  assign any_sgn  = !(ops_unsigned && !ops_mixed);

  mac_mult #(.OP_W(OP_W)) u_mult (
    .a     (op_a),
    .b     (op_b),
    .a_sgn (any_sgn),
    .b_sgn (both_sgn),
    .dbl   (frac_mode && both_sgn),
    .prod  (prod),
    .sat   (prod_sat)
  );

  mac_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_accum (
    .acc_q    (acc_q),
    .prod     (prod),
    .op       (acc_op),
    .sgn      (any_sgn),
    .clamp_rw (acc_clamp32),
    .acc_d    (acc_d),
    .ovf      (acc_ovf)
  );

  mac_extract #(.OP_W(OP_W), .ACC_W(ACC_W)) u_extract (
    .acc   (acc_d),
    .sgn   (any_sgn),
    .frac  (frac_mode),
    .trunc (trunc_half),
    .word  (word_sel),
    .res   (res_d),
    .sat   (res_sat)
  );

  always_comb begin
    ovf_d = prod_sat | acc_ovf | res_sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      acc_q <= acc_d;
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc_o = acc_q;
  assign res_o = res_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic [OP_W-1:0]    op_a,
  input logic [OP_W-1:0]    op_b,
  input logic               ops_unsigned,
  input logic               ops_mixed,
  input logic               frac_mode,
  input logic               acc_clamp32,
  input logic               word_sel,
  input logic [1:0]         acc_op,
  input logic [ACC_W-1:0]   acc_o,
  input logic [2*OP_W-1:0]  res_o,
  input logic               ovf_o
);
  localparam int RW = 2*OP_W;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_o) && $stable(res_o) && $stable(ovf_o)));

  assert_minus_one_sq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frac_mode && !ops_unsigned && !ops_mixed && acc_op == 2'b00 &&
     !acc_clamp32 && word_sel && op_a == {1'b1, {(OP_W-1){1'b0}}} &&
     op_b == {1'b1, {(OP_W-1){1'b0}}})
    |=> (res_o == {1'b0, {(RW-1){1'b1}}} && ovf_o));

  assert_load_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !acc_clamp32 && (acc_op == 2'b00 || acc_op == 2'b11) && op_a == '0)
    |=> (acc_o == '0));

  assert_clamp32_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc_clamp32 && !(ops_unsigned && !ops_mixed))
    |=> (acc_o[ACC_W-1:RW-1] == '0 || acc_o[ACC_W-1:RW-1] == '1));

  assert_unsigned_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !word_sel && ops_unsigned && !ops_mixed)
    |=> (res_o[RW-1:OP_W] == '0));
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .op_a         (op_a),
  .op_b         (op_b),
  .ops_unsigned (ops_unsigned),
  .ops_mixed    (ops_mixed),
  .frac_mode    (frac_mode),
  .acc_clamp32  (acc_clamp32),
  .word_sel     (word_sel),
  .acc_op       (acc_op),
  .acc_o        (acc_o),
  .res_o        (res_o),
  .ovf_o        (ovf_o)
);

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [15:0] op_a, op_b;
  logic        ops_unsigned, ops_mixed, frac_mode, trunc_half;
  logic        acc_clamp32, word_sel;
  logic [1:0]  acc_op;
  logic [39:0] acc_o;
  logic [31:0] res_o;
  logic        ovf_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [39:0] m_acc;
  logic [31:0] m_res;
  logic        m_ovf;

  mac_unit u_mac_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .op_a(op_a), .op_b(op_b),
    .ops_unsigned(ops_unsigned), .ops_mixed(ops_mixed), .frac_mode(frac_mode),
    .trunc_half(trunc_half), .acc_clamp32(acc_clamp32), .word_sel(word_sel),
    .acc_op(acc_op), .acc_o(acc_o), .res_o(res_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v, input int w, input bit sg, inout bit o);
    longint hi, lo;
    hi = sg ? (longint'(1) <<< (w-1)) - 1 : (longint'(1) <<< w) - 1;
    lo = sg ? -(longint'(1) <<< (w-1)) : 0;
    if (v > hi) begin o = 1; return hi; end
    if (v < lo) begin o = 1; return lo; end
    return v;
  endfunction

  // Reference model written from the requirements
  task automatic model(input logic [15:0] a, input logic [15:0] b, input bit u,
                       input bit m, input bit f, input bit t, input bit c32,
                       input bit w, input logic [1:0] op);
    longint av, bv, p, accv, s, v, q;
    bit sg, o;
    sg = !(u && !m);
    av = sg ? longint'($signed(a)) : longint'({48'd0, a});
    bv = (!u && !m) ? longint'($signed(b)) : longint'({48'd0, b});
    p = av * bv;
    o = 0;
    if (f && !u && !m) begin
      p = p * 2;
      if (p > 64'sh7FFFFFFF) begin p = 64'sh7FFFFFFF; o = 1; end
    end
    accv = sg ? longint'($signed(m_acc)) : longint'({24'd0, m_acc});
    case (op)
      2'b01: s = accv + p;
      2'b10: s = accv - p;
      default: s = p;
    endcase
    if (c32) s = clampv(s, 32, sg, o);
    else begin
      bit o40;
      o40 = 0;
      void'(clampv(s, 40, sg, o40));
      if (o40) o = 1;
    end
    m_acc = s[39:0];
    v = sg ? longint'($signed(m_acc)) : longint'({24'd0, m_acc});
    if (w) m_res = 32'(clampv(v, 32, sg, o));
    else begin
      if (f) q = (t ? v : v + 64'sh8000) >>> 16;
      else   q = v;
      q = clampv(q, 16, sg, o);
      m_res = sg ? {{16{q[15]}}, q[15:0]} : {16'd0, q[15:0]};
    end
    m_ovf = o;
  endtask

  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit u,
                        input bit m, input bit f, input bit t, input bit c32,
                        input bit w, input logic [1:0] op, input string tag);
    en = 1; op_a = a; op_b = b; ops_unsigned = u; ops_mixed = m;
    frac_mode = f; trunc_half = t; acc_clamp32 = c32; word_sel = w; acc_op = op;
    model(a, b, u, m, f, t, c32, w, op);
    @(posedge clk);
    @(negedge clk);
    en = 0;
    chk({tag, " acc"}, 64'(acc_o), 64'(m_acc));
    chk({tag, " res"}, 64'(res_o), 64'(m_res));
    chk({tag, " ovf R11"}, 64'(ovf_o), 64'(m_ovf));
  endtask

  task automatic idle_check();
    en = 0; op_a = $urandom; op_b = $urandom; acc_op = 2'($urandom);
    @(posedge clk);
    @(negedge clk);
    chk("R2 hold acc", 64'(acc_o), 64'(m_acc));
    chk("R2 hold res", 64'(res_o), 64'(m_res));
    chk("R2 hold ovf", 64'(ovf_o), 64'(m_ovf));
  endtask

  function automatic logic [15:0] pick();
    int k;
    k = int'($urandom % 8);
    case (k)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h0000;
      3: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; en = 0; op_a = 0; op_b = 0; ops_unsigned = 0; ops_mixed = 0;
    frac_mode = 0; trunc_half = 0; acc_clamp32 = 0; word_sel = 0; acc_op = 0;
    m_acc = 0; m_res = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset acc", 64'(acc_o), 64'd0);
    chk("R1 reset res", 64'(res_o), 64'd0);
    chk("R1 reset ovf", 64'(ovf_o), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release acc", 64'(acc_o), 64'd0);

    // R4: -1.0 * -1.0
    run_op(16'h8000, 16'h8000, 0, 0, 1, 0, 0, 1, 2'b00, "R4");
    chk("R4 word", 64'(res_o), 64'h7FFFFFFF);
    chk("R4 flag", 64'(ovf_o), 64'd1);

    // R7 / R8: 0.5 * 2^-15 gives accumulator 0x8000
    run_op(16'h4000, 16'h0001, 0, 0, 1, 0, 0, 0, 2'b00, "R7");
    chk("R7 round up", 64'(res_o), 64'h1);
    run_op(16'h4000, 16'h0001, 0, 0, 1, 1, 0, 0, 2'b00, "R8");
    chk("R8 truncate", 64'(res_o), 64'h0);

    // R9: integer half saturation
    run_op(16'h0100, 16'h0100, 0, 0, 0, 0, 0, 0, 2'b00, "R9");
    chk("R9 sat", 64'(res_o), 64'h7FFF);
    chk("R9 flag", 64'(ovf_o), 64'd1);

    // R3: mixed and unsigned products
    run_op(16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 0, 1, 2'b00, "R3 mixed");
    chk("R3 mixed word", 64'(res_o), 64'hFFFF0001);
    run_op(16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 0, 1, 2'b00, "R3 unsigned");
    chk("R3 unsigned word R10", 64'(res_o), 64'hFFFE0001);
    run_op(16'h4000, 16'h4000, 1, 0, 1, 0, 0, 1, 2'b00, "R3 ufrac noshift");
    chk("R3 ufrac no doubling", 64'(acc_o), 64'h10000000);

    // R5: add and subtract
    run_op(16'd3, 16'd5, 0, 0, 0, 0, 0, 1, 2'b00, "R5 load");
    run_op(16'd2, 16'd4, 0, 0, 0, 0, 0, 1, 2'b10, "R5 sub");
    chk("R5 sub value", 64'(acc_o), 64'd7);
    run_op(16'd1, 16'd9, 0, 0, 0, 0, 0, 1, 2'b01, "R5 add");
    chk("R5 add value", 64'(acc_o), 64'd16);

    // R5: 40-bit wrap after 512 additions of 2^30
    run_op(16'h8000, 16'h8000, 0, 0, 0, 0, 0, 1, 2'b00, "R5 wrap load");
    for (int i = 0; i < 511; i++)
      run_op(16'h8000, 16'h8000, 0, 0, 0, 0, 0, 1, 2'b01, "R5 wrap add");
    chk("R5 wrapped acc", 64'(acc_o), 64'h8000000000);
    chk("R5 wrap flag", 64'(ovf_o), 64'd1);

    // R6: clamp to 32 bits after 8 additions of 2^28
    run_op(16'h4000, 16'h4000, 0, 0, 0, 0, 1, 1, 2'b00, "R6 load");
    for (int i = 0; i < 7; i++)
      run_op(16'h4000, 16'h4000, 0, 0, 0, 0, 1, 1, 2'b01, "R6 add");
    chk("R6 clamped acc", 64'(acc_o), 64'h007FFFFFFF);
    chk("R6 clamp flag", 64'(ovf_o), 64'd1);

    idle_check();

    // Constrained random mix
    for (int i = 0; i < 1500; i++) begin
      bit u, m, f, t, c, w;
      logic [1:0] op;
      string tag;
      u = 1'($urandom); m = ($urandom % 4) == 0; f = 1'($urandom);
      t = 1'($urandom); c = ($urandom % 4) == 0; w = 1'($urandom);
      op = 2'($urandom);
      if (w)      tag = "R10 word";
      else if (!f) tag = "R9 int half";
      else if (t) tag = "R8 trunc half";
      else        tag = "R7 round half";
      if (($urandom % 10) == 0) idle_check();
      else run_op(pick(), pick(), u, m, f, t, c, w, op, tag);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule